// File: doc/BRIEF.md
# Slot Interrupt Router

The router collects the four shared interrupt pins of every slot on a peripheral bus. It folds them onto a small set of numbered bridge interrupt lines. Internal line n is bridge interrupt 32+n, and it is controlled by bit n of each trigger configuration vector. The slot-to-line map is fixed for one board:

- Slot 5 is the on-board multifunction device. Its four pins keep their own order on lines 0 to 3.
- Slots 6 and 7 each own a single line.
- Slots 8 to 12 are add-in slots. Their pins are rotated by slot position, so that neighbouring cards spread their requests over different lines.

A request from a slot outside this map is not routed to a bridge line. It leaves the block on a separate pass-through vector, indexed by its pin number.

Each bridge line is then conditioned by three per-line configuration bits: edge select, polarity and enable. An edge-selected line turns a rising request into a single-cycle pulse. A level line drives the processor interrupt high only while it is asserted and its polarity bit is set. The conditioned lines are ORed into one registered processor interrupt. The raw state of every bridge line is also presented on a status port, whatever its enable bit.

Top module: `slot_irq_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_irq` and `line_status` are all zero.
- R2: Pin p (0..3) of slot 5 drives bridge line p.
- R3: Any pin of slot 6 drives bridge line 4, and any pin of slot 7 drives bridge line 5.
- R4: Pin p of slot s, for s in 8..12, drives bridge line (s − 8 + p) + 6.
- R5: A request on pin p of any slot not named in R2–R4 sets bit p of `legacy_req` in the same cycle (combinational) and sets no bit of `line_status`.
- R6: With its edge-select bit set (1 = edge), an enabled line that goes from 0 to 1 between two rising clock edges raises `cpu_irq` for exactly one cycle, even if the request stays high.
- R7: With its edge-select bit clear (level), an enabled asserted line drives `cpu_irq` high one cycle later when its polarity bit is 1 and contributes nothing when its polarity bit is 0.
- R8: A line whose enable bit is 0 never contributes to `cpu_irq`.
- R9: `line_status` bit n equals the mapped request state of line n sampled at the previous rising edge, regardless of enable, edge or polarity settings.
- R10: `cpu_irq` is the OR of all enabled, conditioned lines: it stays high while any one contributing line remains active.
- R11: Slot s pin p is bit 4·s+p of `slot_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_irq | input | NUM_SLOTS*4 | Pin levels, slot s pin p at bit 4·s+p |
| edge_sel | input | NUM_LINES | Per line: 1 = edge triggered, 0 = level |
| polarity | input | NUM_LINES | Per line level drive: 1 = drive high, 0 = drive low |
| enable | input | NUM_LINES | Per line enable mask |
| cpu_irq | output | 1 | Registered processor interrupt |
| line_status | output | NUM_LINES | Registered raw state of each bridge line |
| legacy_req | output | 4 | Pass-through requests of unmapped slots, by pin |

## Verification
`legacy_req` is combinational, so it is checked one time step after the inputs change, before any clock edge. `line_status` and level-driven `cpu_irq` settle through one register and are sampled at the falling edge that follows the next rising edge. An edge pulse is checked at two falling edges: it is high at the first and low at the second while the request is held. All stimulus changes on falling edges, so each sample falls exactly one half period after the register that feeds it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PINS   = 4;
  localparam int LINE_W = 8;

  typedef struct packed {
    logic              hit;
    logic [LINE_W-1:0] line;
  } route_t;

  // Board routing: which bridge line a slot/pin pair lands on.
  function automatic route_t route_of(int unsigned slot, int unsigned pin);
    route_t r;
    r.hit  = 1'b1;
    r.line = '0;
    case (slot)
      5:       r.line = LINE_W'(pin);
      6:       r.line = LINE_W'(4);
      7:       r.line = LINE_W'(5);
      8, 9, 10, 11, 12:
               r.line = LINE_W'(slot - 8 + pin + 6);
      default: r.hit  = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/slot_line_map.sv
module slot_line_map
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_SLOTS*PINS-1:0] slot_irq,
  output logic [NUM_LINES-1:0]      line_raw,
  output logic [PINS-1:0]           legacy_req
);
  localparam int NSRC = NUM_SLOTS * PINS;

  logic [NUM_LINES-1:0] src_line [NSRC];
  logic [PINS-1:0]      src_leg  [NSRC];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam route_t RT = route_of(s, p);
      localparam int     IX = s * PINS + p;
      if (RT.hit && (int'(RT.line) < NUM_LINES)) begin : g_routed
        assign src_line[IX] = slot_irq[IX] ? (NUM_LINES'(1) << RT.line) : '0;
        assign src_leg[IX]  = '0;
      end else if (RT.hit) begin : g_out_of_range
        assign src_line[IX] = '0;
        assign src_leg[IX]  = '0;
      end else begin : g_legacy
        assign src_line[IX] = '0;
        assign src_leg[IX]  = slot_irq[IX] ? (PINS'(1) << p) : '0;
      end
    end
  end

  always_comb begin
    line_raw   = '0;
    legacy_req = '0;
    for (int i = 0; i < NSRC; i++) begin
      line_raw   = line_raw | src_line[i];
      legacy_req = legacy_req | src_leg[i];
    end
  end
endmodule

// File: rtl/line_trigger.sv
module line_trigger #(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] line_raw,
  input  logic [NUM_LINES-1:0] line_prev,
  input  logic [NUM_LINES-1:0] edge_sel,
  input  logic [NUM_LINES-1:0] polarity,
  input  logic [NUM_LINES-1:0] enable,
  output logic [NUM_LINES-1:0] edge_fire,
  output logic [NUM_LINES-1:0] contrib
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic rise;
    logic level_on;
    assign rise         = line_raw[n] & ~line_prev[n];
    assign level_on     = line_raw[n] & polarity[n];
    assign edge_fire[n] = rise;
    assign contrib[n]   = enable[n] & (edge_sel[n] ? rise : level_on);
  end
endmodule

// File: rtl/slot_irq_router.sv
module slot_irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS*PINS-1:0] slot_irq,
  input  logic [NUM_LINES-1:0]      edge_sel,
  input  logic [NUM_LINES-1:0]      polarity,
  input  logic [NUM_LINES-1:0]      enable,
  output logic                      cpu_irq,
  output logic [NUM_LINES-1:0]      line_status,
  output logic [PINS-1:0]           legacy_req
);
  logic [NUM_LINES-1:0] line_raw;
  logic [NUM_LINES-1:0] line_prev;
  logic [NUM_LINES-1:0] edge_fire;
  logic [NUM_LINES-1:0] contrib;

  slot_line_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_map (
    .slot_irq  (slot_irq),
    .line_raw  (line_raw),
    .legacy_req(legacy_req)
  );

  line_trigger #(.NUM_LINES(NUM_LINES)) u_trig (
    .line_raw (line_raw),
    .line_prev(line_prev),
    .edge_sel (edge_sel),
    .polarity (polarity),
    .enable   (enable),
    .edge_fire(edge_fire),
    .contrib  (contrib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      line_prev <= line_raw;
      cpu_irq   <= |contrib;
    end
  end

  assign line_status = line_prev;

  // R6
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_fire != '0) |=> ((edge_fire & $past(edge_fire)) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((line_raw & enable) == '0) |=> !cpu_irq);

  // R7
  level_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ((line_raw & enable & polarity & ~edge_sel) != '0) |=> cpu_irq);

  // R9
  status_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (line_raw != '0) |=> (line_status != '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cpu_irq && line_status == '0));
endmodule

// File: tb/slot_irq_router_test.sv
module slot_irq_router_test;
  localparam int NS = 16;
  localparam int NL = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS*4-1:0] slot_irq = '0;
  logic [NL-1:0]   edge_sel = '0;
  logic [NL-1:0]   polarity = '0;
  logic [NL-1:0]   enable   = '0;
  logic            cpu_irq;
  logic [NL-1:0]   line_status;
  logic [3:0]      legacy_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  slot_irq_router #(.NUM_SLOTS(NS), .NUM_LINES(NL)) uut (
    .clk(clk), .rst(rst), .slot_irq(slot_irq), .edge_sel(edge_sel),
    .polarity(polarity), .enable(enable), .cpu_irq(cpu_irq),
    .line_status(line_status), .legacy_req(legacy_req)
  );

  // bench restatement of the board map: -1 when unrouted
  function automatic int line_for(int s, int p);
    if (s >= 8 && s <= 12) return s + p - 2;
    if (s == 5) return p;
    if (s == 6 || s == 7) return s - 2;
    return -1;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: during reset
    check(cpu_irq == 1'b0 && line_status == '0, "R1", {cpu_irq, line_status}, 0);
    rst = 1'b0;
    check(cpu_irq == 1'b0 && line_status == '0, "R1", {cpu_irq, line_status}, 0);

    // sweep every slot/pin in level mode, polarity high, all enabled (R2-R5, R11)
    enable = '1; polarity = '1; edge_sel = '0;
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        int ln;
        logic [NL-1:0] ev;
        string tag;
        ln = line_for(s, p);
        ev = (ln < 0) ? '0 : (NL'(1) << ln);
        tag = (s == 5) ? "R2" : (s == 6 || s == 7) ? "R3" :
              (s >= 8 && s <= 12) ? "R4" : "R5";
        slot_irq = '0;
        slot_irq[s*4 + p] = 1'b1;   // R11 bit placement
        #1;
        check(legacy_req == ((ln < 0) ? (4'b1 << p) : 4'b0), "R5 legacy",
              legacy_req, (ln < 0) ? (4'b1 << p) : 4'b0);
        tick();
        check(line_status == ev, tag, line_status, ev);
        check(cpu_irq == (ln >= 0), tag, cpu_irq, ln >= 0);
        slot_irq = '0;
        tick();
        tick();
      end
    end

    // edge mode: each routed line pulses once while its request is held (R6)
    edge_sel = '1;
    for (int ln = 0; ln < 14; ln++) begin
      int s, p;
      if (ln < 4) begin s = 5; p = ln; end
      else if (ln < 6) begin s = ln + 2; p = 0; end
      else if (ln < 10) begin s = 8; p = ln - 6; end
      else begin s = ln - 1; p = 3; end
      slot_irq = '0;
      slot_irq[s*4 + p] = 1'b1;
      tick();
      check(cpu_irq == 1'b1, "R6 pulse", cpu_irq, 1);
      tick();
      check(cpu_irq == 1'b0, "R6 single", cpu_irq, 0);
      check(line_status == (NL'(1) << ln), "R9 edge status", line_status, NL'(1) << ln);
      slot_irq = '0;
      tick();
    end

    // level with polarity clear contributes nothing, status still shows (R7, R9)
    edge_sel = '0; polarity = '1; polarity[4] = 1'b0;
    slot_irq = '0; slot_irq[6*4 + 2] = 1'b1;
    tick(); tick();
    check(cpu_irq == 1'b0, "R7 pol0", cpu_irq, 0);
    check(line_status == (NL'(1) << 4), "R9 pol0", line_status, NL'(1) << 4);
    slot_irq = '0; polarity = '1; tick();

    // disabled line has no effect, raw still reported (R8, R9)
    enable = '1; enable[9] = 1'b0;
    slot_irq[12*4 + 1] = 1'b1;  // line 12-8+1+6 = 11
    slot_irq[8*4 + 3]  = 1'b0;
    slot_irq = '0; slot_irq[9*4 + 2] = 1'b1;  // line 9
    tick(); tick();
    check(cpu_irq == 1'b0, "R8 masked", cpu_irq, 0);
    check(line_status == (NL'(1) << 9), "R9 masked", line_status, NL'(1) << 9);
    edge_sel[9] = 1'b1;
    slot_irq = '0; tick();
    slot_irq[9*4 + 2] = 1'b1; tick();
    check(cpu_irq == 1'b0, "R8 masked edge", cpu_irq, 0);
    slot_irq = '0; enable = '1; edge_sel = '0; tick();

    // OR of two level lines (R10)
    slot_irq[5*4 + 0] = 1'b1;   // line 0
    slot_irq[7*4 + 3] = 1'b1;   // line 5
    tick();
    check(cpu_irq == 1'b1, "R10 both", cpu_irq, 1);
    slot_irq[5*4 + 0] = 1'b0;
    tick();
    check(cpu_irq == 1'b1, "R10 one left", cpu_irq, 1);
    check(line_status == (NL'(1) << 5), "R10 status", line_status, NL'(1) << 5);
    slot_irq = '0;
    tick();
    check(cpu_irq == 1'b0, "R10 none", cpu_irq, 0);

    // reset mid-activity (R1)
    slot_irq[5*4 + 1] = 1'b1; tick();
    rst = 1'b1; tick();
    check(cpu_irq == 1'b0 && line_status == '0, "R1 reassert", {cpu_irq, line_status}, 0);
    rst = 1'b0; slot_irq = '0;
    tick();
    finish_run();
  end
endmodule